// File: doc/BRIEF.md
# Gradient Magnitude Edge Filter

This block turns a raster stream of 8-bit pixels into an edge-strength stream. It builds one 3x3 neighbourhood from a single pair of line stores and a 3x3 register array. Two fixed weighted-difference kernels read that same neighbourhood in parallel. One kernel measures the change across rows and the other the change across columns. The kernels use only shifts and add/subtract, with no multipliers. Each kernel result is a signed value, and its magnitude is taken in a register stage of equal depth in both branches. The two magnitudes are added and clipped to the output width.

Pixels enter with a valid strobe, a start-of-frame marker on the first pixel and an end-of-line marker on the last pixel of each line. The output stream has one pixel for every accepted input pixel, with the same markers, four clock cycles later. The result at stream position (row, col) belongs to the neighbourhood whose newest pixel is that input position. Where that neighbourhood would reach outside the frame, the output is zero.

Top module: `edge_grad_top`

## Requirements
- R1: The row kernel gives V = (t0 + 2*t1 + t2) - (b0 + 2*b1 + b2). Row t is the oldest of the three lines, row b is the current line, and index 0 is the oldest (leftmost) pixel of each row.
- R2: The column kernel gives H = (t0 + 2*m0 + b0) - (t2 + 2*m2 + b2). Here m is the middle line and the same indexing as R1 applies.
- R3: For a full neighbourhood, out_pix = min(|V| + |H|, 2^OUT_W - 1). With OUT_W = 8 the cap is 255.
- R4: Rows and columns count from 0 at the start-of-frame pixel. The output at stream position (row, col) uses input rows row-2..row and columns col-2..col. It is 0 whenever row < 2 or col < 2.
- R5: out_valid, out_sof and out_eol equal in_valid, in_valid&in_sof and in_valid&in_eol from exactly four clock cycles earlier. out_pix in that same cycle is the result for that pixel.
- R6: Cycles with in_valid low change nothing. The line stores and the neighbourhood advance only on valid pixels, so inserting idle cycles between pixels leaves every result unchanged.
- R7: A valid pixel with in_sof high is row 0, column 0, whatever state an earlier (even unfinished) frame left behind.
- R8: A valid pixel with in_eol high ends its line. The next pixel is column 0 of the next row. Lines may hold up to LINE_MAX pixels.
- R9: While rst_n is low, and after reset until the first pixel comes through, out_valid, out_sof, out_eol and out_pix are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present this cycle |
| in_pix | input | PIX_W | Input pixel, unsigned |
| in_sof | input | 1 | First pixel of a frame (qualified by in_valid) |
| in_eol | input | 1 | Last pixel of a line (qualified by in_valid) |
| out_valid | output | 1 | Output pixel present this cycle |
| out_pix | output | OUT_W | Clipped gradient magnitude |
| out_sof | output | 1 | Start-of-frame marker, aligned with out_pix |
| out_eol | output | 1 | End-of-line marker, aligned with out_pix |

## Verification
The bench uses PIX_W = 8, OUT_W = 8 and LINE_MAX = 8. The short line store lets one frame fill it exactly to its last address, and another frame uses lines shorter than the store. Tiny 3x3 frames each hold exactly one full neighbourhood, so every weighted tap, sign case and the clip at 255 can be checked against hand-worked values. Larger frames, with and without idle gaps, are compared with a model in the bench that indexes the stored image directly. An aborted frame followed by a fresh one shows that the position counting restarts.

// File: rtl/edge_pkg.sv
package edge_pkg;
  localparam int KDIM = 3;
  localparam int LAT  = 4;

  typedef enum logic {
    KERN_ROWDIFF = 1'b0,
    KERN_COLDIFF = 1'b1
  } kern_e;

  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
  } ctl_t;

  // weighted tap sum a + 2b + c, the only arithmetic the kernels need
  function automatic int wsum3(input int a, input int b, input int c);
    return a + (b <<< 1) + c;
  endfunction

  function automatic int mag_abs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int sat_cap(input int v, input int cap);
    return (v > cap) ? cap : v;
  endfunction
endpackage

// File: rtl/edge_pos_track.sv
module edge_pos_track #(
  parameter int LINE_MAX = 512
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sof,
  input  logic                        in_eol,
  output logic [$clog2(LINE_MAX)-1:0] col_addr,
  output logic                        win_full
);
  import edge_pkg::*;
  localparam int CW      = $clog2(LINE_MAX);
  localparam int ROW_TOP = KDIM - 1;

  logic [CW-1:0] nxt_col;
  logic [1:0]    nxt_row;
  logic [1:0]    cur_row;

  // a start-of-frame pixel is always position (0,0)
  assign col_addr = in_sof ? '0 : nxt_col;
  assign cur_row  = in_sof ? 2'd0 : nxt_row;
  assign win_full = (cur_row == 2'(ROW_TOP)) && (col_addr >= CW'(ROW_TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_col <= '0;
      nxt_row <= '0;
    end else if (in_valid) begin
      if (in_eol) begin
        nxt_col <= '0;
        nxt_row <= (cur_row == 2'(ROW_TOP)) ? cur_row : cur_row + 2'd1;
      end else begin
        nxt_col <= col_addr + CW'(1);
        nxt_row <= cur_row;
      end
    end
  end
endmodule

// File: rtl/edge_win_gen.sv
module edge_win_gen #(
  parameter int PIX_W    = 8,
  parameter int LINE_MAX = 512
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              in_valid,
  input  logic [PIX_W-1:0]                                  in_pix,
  input  logic [$clog2(LINE_MAX)-1:0]                       col_addr,
  output logic [edge_pkg::KDIM-1:0][edge_pkg::KDIM-1:0][PIX_W-1:0] win
);
  import edge_pkg::*;
  localparam int NLB = KDIM - 1;

  logic [PIX_W-1:0]            lbuf [NLB][LINE_MAX];
  logic [KDIM-1:0][PIX_W-1:0]  col_vec;

  assign col_vec[KDIM-1] = in_pix;

  // line store chain: store k holds the line k+1 steps back
  for (genvar k = 0; k < NLB; k++) begin : g_lb
    assign col_vec[KDIM-2-k] = lbuf[k][col_addr];
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (in_valid) lbuf[k][col_addr] <= in_pix;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (in_valid) lbuf[k][col_addr] <= lbuf[k-1][col_addr];
      end
    end
  end

  // neighbourhood registers: column 0 oldest, row 0 oldest line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (in_valid) begin
      for (int r = 0; r < KDIM; r++) begin
        for (int c = 0; c < KDIM - 1; c++) begin
          win[r][c] <= win[r][c+1];
        end
        win[r][KDIM-1] <= col_vec[r];
      end
    end
  end
endmodule

// File: rtl/edge_kernel.sv
module edge_kernel #(
  parameter int              PIX_W = 8,
  parameter edge_pkg::kern_e KSEL  = edge_pkg::KERN_ROWDIFF
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic [edge_pkg::KDIM-1:0][edge_pkg::KDIM-1:0][PIX_W-1:0] win,
  output logic signed [PIX_W+2:0]                           grad
);
  import edge_pkg::*;
  localparam int GRAD_W = PIX_W + 3;
  localparam int LAST   = KDIM - 1;

  int lead;
  int trail;

  if (KSEL == KERN_ROWDIFF) begin : g_row
    always_comb begin
      lead  = wsum3(int'(win[0][0]), int'(win[0][1]), int'(win[0][2]));
      trail = wsum3(int'(win[LAST][0]), int'(win[LAST][1]), int'(win[LAST][2]));
    end
  end else begin : g_col
    always_comb begin
      lead  = wsum3(int'(win[0][0]), int'(win[1][0]), int'(win[2][0]));
      trail = wsum3(int'(win[0][LAST]), int'(win[1][LAST]), int'(win[2][LAST]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grad <= '0;
    else        grad <= GRAD_W'(lead - trail);
  end
endmodule

// File: rtl/edge_mag.sv
module edge_mag #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PIX_W+2:0] gx,
  input  logic signed [PIX_W+2:0] gy,
  input  logic                    full_s3,
  output logic [PIX_W+1:0]        abs_x,
  output logic [PIX_W+1:0]        abs_y,
  output logic [PIX_W+2:0]        sum_raw,
  output logic [OUT_W-1:0]        mag
);
  import edge_pkg::*;
  localparam int ABS_W   = PIX_W + 2;
  localparam int SUM_W   = ABS_W + 1;
  localparam int OUT_MAX = (1 << OUT_W) - 1;

  // both branches take one register here, so they meet in step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abs_x <= '0;
      abs_y <= '0;
    end else begin
      abs_x <= ABS_W'(mag_abs(int'(gx)));
      abs_y <= ABS_W'(mag_abs(int'(gy)));
    end
  end

  assign sum_raw = SUM_W'(int'(abs_x) + int'(abs_y));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mag <= '0;
    else if (full_s3) mag <= OUT_W'(sat_cap(int'(sum_raw), OUT_MAX));
    else              mag <= '0;
  end
endmodule

// File: rtl/edge_grad_top.sv
module edge_grad_top #(
  parameter int PIX_W    = 8,
  parameter int OUT_W    = 8,
  parameter int LINE_MAX = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_pix,
  output logic             out_sof,
  output logic             out_eol
);
  import edge_pkg::*;
  localparam int CW     = $clog2(LINE_MAX);
  localparam int GRAD_W = PIX_W + 3;
  localparam int FULL_D = LAT - 1;

  logic [CW-1:0]                       col_addr;
  logic                                win_full;
  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0] window;
  logic signed [GRAD_W-1:0]            grad_v;
  logic signed [GRAD_W-1:0]            grad_h;
  logic [PIX_W+1:0]                    abs_x;
  logic [PIX_W+1:0]                    abs_y;
  logic [PIX_W+2:0]                    sum_raw;
  logic [PIX_W-1:0]                    win_mid;
  logic                                s3_full;

  ctl_t ctl_in;
  ctl_t ctl_pipe [LAT];
  logic full_pipe [FULL_D];

  edge_pos_track #(.LINE_MAX(LINE_MAX)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .col_addr(col_addr), .win_full(win_full)
  );

  edge_win_gen #(.PIX_W(PIX_W), .LINE_MAX(LINE_MAX)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .col_addr(col_addr), .win(window)
  );

  edge_kernel #(.PIX_W(PIX_W), .KSEL(KERN_ROWDIFF)) u_kv (
    .clk(clk), .rst_n(rst_n), .win(window), .grad(grad_v)
  );

  edge_kernel #(.PIX_W(PIX_W), .KSEL(KERN_COLDIFF)) u_kh (
    .clk(clk), .rst_n(rst_n), .win(window), .grad(grad_h)
  );

  edge_mag #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_mag (
    .clk(clk), .rst_n(rst_n), .gx(grad_v), .gy(grad_h), .full_s3(s3_full),
    .abs_x(abs_x), .abs_y(abs_y), .sum_raw(sum_raw), .mag(out_pix)
  );

  assign ctl_in  = '{valid: in_valid, sof: in_valid & in_sof, eol: in_valid & in_eol};
  assign win_mid = window[1][1];
  assign s3_full = full_pipe[FULL_D-1];

  // marker delay line matched to the data path
  for (genvar i = 0; i < LAT; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_pipe[i] <= '0;
      else if (i == 0) ctl_pipe[i] <= ctl_in;
      else             ctl_pipe[i] <= ctl_pipe[(i == 0) ? 0 : i-1];
    end
  end

  for (genvar i = 0; i < FULL_D; i++) begin : g_full
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full_pipe[i] <= 1'b0;
      else if (i == 0) full_pipe[i] <= in_valid & win_full;
      else             full_pipe[i] <= full_pipe[(i == 0) ? 0 : i-1];
    end
  end

  assign out_valid = ctl_pipe[LAT-1].valid;
  assign out_sof   = ctl_pipe[LAT-1].sof;
  assign out_eol   = ctl_pipe[LAT-1].eol;
endmodule

// File: rtl/edge_grad_chk.sv
module edge_grad_chk #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eol,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eol,
  input logic [OUT_W-1:0] out_pix,
  input logic [PIX_W+1:0] abs_x,
  input logic [PIX_W+1:0] abs_y,
  input logic [PIX_W+2:0] sum_raw,
  input logic             s3_full,
  input logic [PIX_W-1:0] win_mid
);
  localparam int GMAX    = 4 * ((1 << PIX_W) - 1);
  localparam int OUT_MAX = (1 << OUT_W) - 1;

  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4))); // R5
  AST_SOF_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4) |-> (out_sof == $past(in_valid && in_sof, 4))); // R5
  AST_EOL_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4) |-> (out_eol == $past(in_valid && in_eol, 4))); // R5
  AST_FRAME_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_pix == '0)); // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(abs_x) <= GMAX); // R1
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(abs_y) <= GMAX); // R2
  AST_SAT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_full && int'(sum_raw) > OUT_MAX) |=> (int'(out_pix) == OUT_MAX)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(win_mid)); // R6
endmodule

bind edge_grad_top edge_grad_chk #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eol(in_eol), .out_valid(out_valid), .out_sof(out_sof),
  .out_eol(out_eol), .out_pix(out_pix), .abs_x(abs_x), .abs_y(abs_y),
  .sum_raw(sum_raw), .s3_full(s3_full), .win_mid(win_mid)
);

// File: tb/sim_edge_grad_top.sv
`timescale 1ns/1ps
module sim_edge_grad_top;
  localparam int PIX_W    = 8;
  localparam int OUT_W    = 8;
  localparam int LINE_MAX = 8;
  localparam int NTAB     = 12;

  // taps t0 t1 t2 m0 m1 m2 b0 b1 b2, then the hand-worked magnitude
  localparam int TBL [NTAB][10] = '{
    '{ 10, 10, 10, 10, 10, 10, 10, 10, 10,   0},
    '{255,255,255,  0,  0,  0,  0,  0,  0, 255},
    '{ 10, 10, 10,  0,  0,  0,  0,  0,  0,  40},
    '{ 20,  0,  0, 20,  0,  0, 20,  0,  0,  80},
    '{  0,  0,  5,  0,  0,  5,  0,  0,  5,  20},
    '{  0,  0,  0,  0,  0,  0,  3,  3,  3,  12},
    '{  0,  0,  0,  0,100,  0,  0,  0,  0,   0},
    '{ 50,  0,  0,  0,  0,  0,  0,  0,  0, 100},
    '{  0,  0,  0,  0,  0,  0,  0,  0, 30,  60},
    '{  0, 40,  0,  0,  0, 25,  0,  0,  0, 130},
    '{ 60, 60, 60, 60,  0,  0, 60,  0,  0, 255},
    '{  0,  0, 10,  0,  0,  0, 10,  0,  0,   0}
  };
  localparam string TAGS [NTAB] = '{"R3","R3","R1","R2","R2","R1",
                                    "R1","R3","R3","R3","R3","R3"};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             in_sof = 1'b0;
  logic             in_eol = 1'b0;
  logic             out_valid;
  logic [OUT_W-1:0] out_pix;
  logic             out_sof;
  logic             out_eol;

  int checks = 0;
  int failures = 0;
  int frm [64];
  int cap_pix [128];
  int cap_sof [128];
  int cap_eol [128];
  int cap_n = 0;

  always #2 clk = ~clk;

  edge_grad_top #(.PIX_W(PIX_W), .OUT_W(OUT_W), .LINE_MAX(LINE_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
    .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < 128) begin
      cap_pix[cap_n] = int'(out_pix);
      cap_sof[cap_n] = int'(out_sof);
      cap_eol[cap_n] = int'(out_eol);
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_at(input int r, input int c, input int w);
    int p [3][3];
    int v, h, s;
    if (r < 2 || c < 2) return 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        p[i][j] = frm[(r - 2 + i) * w + (c - 2 + j)];
    v = (p[0][0] + 2 * p[0][1] + p[0][2]) - (p[2][0] + 2 * p[2][1] + p[2][2]);
    h = (p[0][0] + 2 * p[1][0] + p[2][0]) - (p[0][2] + 2 * p[1][2] + p[2][2]);
    s = (v < 0 ? -v : v) + (h < 0 ? -h : h);
    return (s > 255) ? 255 : s;
  endfunction

  task automatic drive_frame(input int h, input int w, input int gap);
    cap_n = 0;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = PIX_W'(frm[r * w + c]);
        in_sof   = (r == 0 && c == 0);
        in_eol   = (c == w - 1);
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // compares the captured stream with the bench model; border -> R4
  task automatic check_frame(input int h, input int w, input string tag);
    chk(cap_n == h * w, "R5 count", cap_n, h * w);
    for (int i = 0; i < h * w && i < cap_n; i++) begin
      int r = i / w;
      int c = i % w;
      int e = model_at(r, c, w);
      chk(cap_pix[i] == e, (r < 2 || c < 2) ? "R4" : tag, cap_pix[i], e);
      chk(cap_sof[i] == (i == 0 ? 1 : 0), "R5 sof", cap_sof[i], i == 0 ? 1 : 0);
      chk(cap_eol[i] == (c == w - 1 ? 1 : 0), "R8 eol", cap_eol[i], c == w - 1 ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    chk(out_pix == '0, "R9 pix in reset", int'(out_pix), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && out_sof == 1'b0 && out_eol == 1'b0, "R9 after reset",
        int'(out_valid), 0);
    chk(out_pix == '0, "R9 pix after reset", int'(out_pix), 0);

    // table walk: one 3x3 frame per entry, varying idle gaps (R6, R7)
    for (int t = 0; t < NTAB; t++) begin
      for (int k = 0; k < 9; k++) frm[k] = TBL[t][k];
      drive_frame(3, 3, t % 3);
      chk(cap_n == 9, "R5 count", cap_n, 9);
      for (int k = 0; k < 8; k++) chk(cap_pix[k] == 0, "R4", cap_pix[k], 0);
      chk(cap_pix[8] == TBL[t][9], TAGS[t], cap_pix[8], TBL[t][9]);
    end

    // R5 latency: output valid on the fourth falling edge after driving
    @(negedge clk);
    in_valid = 1'b1; in_pix = 8'd9; in_sof = 1'b1; in_eol = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
      if (k < 4) chk(out_valid == 1'b0, "R5 early", int'(out_valid), 0);
      else chk(out_valid == 1'b1 && out_sof == 1'b1, "R5 latency", int'(out_valid), 1);
    end
    repeat (4) @(negedge clk);

    // R7: abort a frame after partial rows, then restart with a fresh one
    for (int k = 0; k < 64; k++) frm[k] = (k * 71 + 13) % 256;
    drive_frame(2, 6, 0);
    for (int k = 0; k < 30; k++) frm[k] = (k / 6 * 53 + (k % 6) * (k % 6) * 29 + 7) % 256;
    drive_frame(5, 6, 0);
    check_frame(5, 6, "R7");

    // R6: same image with idle cycles between pixels
    drive_frame(5, 6, 2);
    check_frame(5, 6, "R6");

    // R8: lines exactly LINE_MAX long
    for (int k = 0; k < 32; k++) frm[k] = (k * k * 17 + k * 5) % 256;
    drive_frame(4, LINE_MAX, 0);
    check_frame(4, LINE_MAX, "R8");

    // R9 again: reset asserted mid-stream clears the outputs at once
    for (int k = 0; k < 9; k++) frm[k] = 200;
    @(negedge clk);
    in_valid = 1'b1; in_pix = 8'd200; in_sof = 1'b1;
    @(negedge clk);
    in_sof = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0 && out_pix == '0, "R9 mid reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle after reset", int'(out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule